// File: doc/BRIEF.md
# Transmit FIFO Start Controller

This block decides when a frame transmitter may begin draining the frame at the head of a transmit FIFO. It watches the FIFO occupancy together with the write and read strobes and their end-of-frame flags, and keeps a count of the complete frames currently stored. While idle, it compares the occupancy against a byte threshold picked by a 3-bit code. Transmission is released as soon as that level is reached or a whole frame is present, whichever happens first. When the store-and-forward bit is set, the threshold is ignored and only a complete frame releases transmission.

Once released, the start signal holds until the transmitter reads the end-of-frame byte. If the FIFO is empty while a frame is still being sent, the block reports an abort. It then asks the FIFO to discard bytes up to the aborted frame's end marker before it evaluates the next frame. The configuration inputs are consulted only while idle, so they cannot change a frame already in flight.

Top module: `txs_start_ctrl`

## Requirements
- R1: After reset is released, tx_start, tx_abort and drop_req are all low.
- R2: The threshold code selects a byte level: code 0 gives 64, 1 gives 128, 2 gives 192, 3 gives 256, 4 gives 40, 5 gives 32, 6 gives 24 and 7 gives 16. When idle with cfg_sf low, an occupancy at or above that level raises tx_start at the next clock edge.
- R3: When idle with occupancy below the threshold and no complete frame stored, tx_start stays low.
- R4: A write with wr_eof set makes a frame complete at the following edge. With cfg_sf low, tx_start then rises at the next edge, whatever the occupancy.
- R5: With cfg_sf high, tx_start rises only for a complete frame, even when the occupancy is at or above any threshold.
- R6: Once high, tx_start stays high until an edge where rd_en and rd_eof are both set, and is low after that edge.
- R7: An edge where tx_start is high, fifo_level is 0 and no end-of-frame byte is read drops tx_start and produces a single-cycle tx_abort pulse after that edge.
- R8: After an abort, drop_req stays high and tx_start stays low until an edge with rd_en and rd_eof both set. After that edge drop_req is low and the block is idle.
- R9: Changes to cfg_thr_code and cfg_sf while tx_start is high have no effect on tx_start.
- R10: An edge that both writes and reads an end-of-frame byte leaves the count of complete frames unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_thr_code | input | 3 | Threshold code (see R2) |
| cfg_sf | input | 1 | Store-and-forward: wait for a complete frame |
| fifo_level | input | LVL_W | Current FIFO occupancy in bytes |
| wr_en | input | 1 | Byte written into the FIFO this cycle |
| wr_eof | input | 1 | Written byte ends its frame |
| rd_en | input | 1 | Byte popped from the FIFO this cycle |
| rd_eof | input | 1 | Popped byte ends its frame |
| tx_start | output | 1 | Transmitter may send the head frame |
| tx_abort | output | 1 | One-cycle underflow abort pulse |
| drop_req | output | 1 | Request to pop and discard the aborted frame |

## Verification
Two events can land on the same edge: an end-of-frame byte written for a later frame and the end-of-frame byte of the head frame being read. The bench forces both during transmission and then checks that the next frame starts on a complete-frame basis with store-and-forward set. It also reads out that second frame and checks that no phantom third frame is released. A second overlap is an abort raised while the occupancy would meet the threshold. This is judged by tx_start staying low throughout the discard.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_DROP = 2'd2
  } txs_state_e;

  localparam int THR_W = 9;

  function automatic logic [THR_W-1:0] thr_bytes(input logic [2:0] code);
    logic [THR_W-1:0] b;
    if (!code[2]) b = THR_W'({code[1:0], 6'd0}) + THR_W'(64);
    else          b = THR_W'(40) - THR_W'({code[1:0], 3'd0});
    return b;
  endfunction
endpackage

// File: rtl/txs_frame_tracker.sv
module txs_frame_tracker #(
  parameter int CNT_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic eof_in,
  input  logic eof_out,
  output logic frame_ready
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = eof_in ^ eof_out;
    cnt_d  = cnt_q;
    if (eof_in && !eof_out)      cnt_d = cnt_q + CNT_W'(1);
    else if (!eof_in && eof_out) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign frame_ready = (cnt_q != '0);
endmodule

// File: rtl/txs_thresh_decode.sv
module txs_thresh_decode #(
  parameter int LVL_W = 10
) (
  input  logic [2:0]       thr_code,
  input  logic             sf_mode,
  input  logic [LVL_W-1:0] level,
  input  logic             frame_ready,
  output logic             go
);
  import txs_pkg::*;
  logic [31:0] lvl32, thr32;
  logic        lvl_hit;

  always_comb begin
    lvl32   = 32'(level);
    thr32   = 32'(thr_bytes(thr_code));
    lvl_hit = (lvl32 >= thr32);
    go      = sf_mode ? frame_ready : (frame_ready || lvl_hit);
  end
endmodule

// File: rtl/txs_start_ctrl.sv
module txs_start_ctrl #(
  parameter int DEPTH = 512,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_thr_code,
  input  logic             cfg_sf,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             wr_en,
  input  logic             wr_eof,
  input  logic             rd_en,
  input  logic             rd_eof,
  output logic             tx_start,
  output logic             tx_abort,
  output logic             drop_req
);
  import txs_pkg::*;
  localparam int CNT_W = $clog2(DEPTH + 1);

  txs_state_e state_q, state_d;
  logic       abort_q, abort_d;
  logic       frame_ready, go, eof_wr, eof_rd, fifo_empty;

  assign eof_wr     = wr_en && wr_eof;
  assign eof_rd     = rd_en && rd_eof;
  assign fifo_empty = (fifo_level == '0);

  txs_frame_tracker #(.CNT_W(CNT_W)) u_trk (
    .clk         (clk),
    .rst_n       (rst_n),
    .eof_in      (eof_wr),
    .eof_out     (eof_rd),
    .frame_ready (frame_ready)
  );

  txs_thresh_decode #(.LVL_W(LVL_W)) u_dec (
    .thr_code    (cfg_thr_code),
    .sf_mode     (cfg_sf),
    .level       (fifo_level),
    .frame_ready (frame_ready),
    .go          (go)
  );

  always_comb begin
    state_d = state_q;
    abort_d = 1'b0;
    unique case (state_q)
      ST_IDLE: if (go) state_d = ST_SEND;
      ST_SEND: begin
        if (eof_rd) state_d = ST_IDLE;
        else if (fifo_empty) begin
          state_d = ST_DROP;
          abort_d = 1'b1;
        end
      end
      ST_DROP: if (eof_rd) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= abort_d;
    end
  end

  assign tx_start = (state_q == ST_SEND);
  assign drop_req = (state_q == ST_DROP);
  assign tx_abort = abort_q;
endmodule

// File: rtl/txs_start_ctrl_chk.sv
module txs_start_ctrl_chk #(
  parameter int LVL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] fifo_level,
  input logic             rd_en,
  input logic             rd_eof,
  input logic             tx_start,
  input logic             tx_abort,
  input logic             drop_req
);
  // R7
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> !tx_abort);
  // R7
  abort_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> (!tx_start && drop_req));
  // R7
  underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && fifo_level == '0 && !(rd_en && rd_eof)) |=> tx_abort);
  // R6
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && fifo_level != '0 && !(rd_en && rd_eof)) |=> tx_start);
  // R8
  drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_start && drop_req));
  // R8
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_req && !(rd_en && rd_eof)) |=> drop_req);
endmodule

bind txs_start_ctrl txs_start_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_level (fifo_level),
  .rd_en      (rd_en),
  .rd_eof     (rd_eof),
  .tx_start   (tx_start),
  .tx_abort   (tx_abort),
  .drop_req   (drop_req)
);

// File: tb/test_txs_start_ctrl.sv
`timescale 1ns/1ps
module test_txs_start_ctrl;
  localparam int LVL_W = 10;
  localparam int NV = 16;
  // {code[14:12], sf[11], level[10:1], expected start[0]}
  localparam logic [14:0] VEC [NV] = '{
    {3'd0, 1'b0, 10'd64,  1'b1}, {3'd0, 1'b0, 10'd63,  1'b0},
    {3'd1, 1'b0, 10'd128, 1'b1}, {3'd1, 1'b0, 10'd127, 1'b0},
    {3'd2, 1'b0, 10'd192, 1'b1}, {3'd3, 1'b0, 10'd255, 1'b0},
    {3'd3, 1'b0, 10'd256, 1'b1}, {3'd4, 1'b0, 10'd40,  1'b1},
    {3'd4, 1'b0, 10'd39,  1'b0}, {3'd5, 1'b0, 10'd32,  1'b1},
    {3'd6, 1'b0, 10'd23,  1'b0}, {3'd6, 1'b0, 10'd24,  1'b1},
    {3'd7, 1'b0, 10'd16,  1'b1}, {3'd7, 1'b0, 10'd15,  1'b0},
    {3'd7, 1'b1, 10'd300, 1'b0}, {3'd0, 1'b1, 10'd511, 1'b0}
  };

  logic clk = 1'b0, rst_n;
  logic [2:0] cfg_thr_code;
  logic cfg_sf, wr_en, wr_eof, rd_en, rd_eof;
  logic [LVL_W-1:0] fifo_level;
  logic tx_start, tx_abort, drop_req;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  txs_start_ctrl i_txs_start_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_thr_code(cfg_thr_code), .cfg_sf(cfg_sf),
    .fifo_level(fifo_level), .wr_en(wr_en), .wr_eof(wr_eof), .rd_en(rd_en),
    .rd_eof(rd_eof), .tx_start(tx_start), .tx_abort(tx_abort), .drop_req(drop_req)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle_in();
    wr_en = 0; wr_eof = 0; rd_en = 0; rd_eof = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; idle_in(); cfg_thr_code = 3'd0; cfg_sf = 0; fifo_level = '0;
    #10; tick(); rst_n = 1;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 start", tx_start, 1'b0);
    chk("R1 abort", tx_abort, 1'b0);
    chk("R1 drop", drop_req, 1'b0);

    // R2 R3 R5 threshold table walk
    for (int i = 0; i < NV; i++) begin
      do_reset();
      cfg_thr_code = VEC[i][14:12]; cfg_sf = VEC[i][11]; fifo_level = VEC[i][10:1];
      tick();
      chk(VEC[i][0] ? "R2 level start" : "R3 R5 no start", tx_start, VEC[i][0]);
    end

    // R4 complete frame below threshold
    do_reset();
    fifo_level = 10'd5; wr_en = 1; wr_eof = 1;
    tick(); idle_in();
    chk("R4 not yet", tx_start, 1'b0);
    tick();
    chk("R4 frame start", tx_start, 1'b1);
    // R9 config change mid-frame
    cfg_thr_code = 3'd3; cfg_sf = 1; fifo_level = 10'd2;
    tick();
    chk("R9 cfg ignored", tx_start, 1'b1);
    // R6 end of frame read
    rd_en = 1; rd_eof = 1;
    tick(); idle_in(); fifo_level = '0;
    chk("R6 release", tx_start, 1'b0);
    tick();
    chk("R6 stays idle", tx_start, 1'b0);

    // R5 store-and-forward waits for complete frame
    do_reset();
    cfg_sf = 1; fifo_level = 10'd511;
    tick();
    chk("R5 wait", tx_start, 1'b0);
    wr_en = 1; wr_eof = 1;
    tick(); idle_in(); tick();
    chk("R5 frame start", tx_start, 1'b1);

    // R7 underflow abort
    do_reset();
    cfg_thr_code = 3'd7; fifo_level = 10'd16;
    tick();
    chk("R7 started", tx_start, 1'b1);
    fifo_level = '0;
    tick();
    chk("R7 abort pulse", tx_abort, 1'b1);
    chk("R7 start drop", tx_start, 1'b0);
    chk("R8 drop on", drop_req, 1'b1);
    fifo_level = 10'd20; rd_en = 1;
    tick();
    chk("R7 abort one cycle", tx_abort, 1'b0);
    chk("R8 no start while drop", tx_start, 1'b0);
    chk("R8 drop held", drop_req, 1'b1);
    rd_en = 0; wr_en = 1; wr_eof = 1;
    tick(); idle_in();
    chk("R8 drop held eof written", drop_req, 1'b1);
    rd_en = 1; rd_eof = 1; fifo_level = 10'd1;
    tick(); idle_in(); fifo_level = '0;
    chk("R8 drop done", drop_req, 1'b0);
    tick();
    chk("R8 idle after drop", tx_start, 1'b0);

    // R10 simultaneous eof write and eof read
    do_reset();
    cfg_sf = 1; fifo_level = 10'd4; wr_en = 1; wr_eof = 1;
    tick(); idle_in(); tick();
    chk("R10 frame A start", tx_start, 1'b1);
    wr_en = 1; wr_eof = 1; rd_en = 1; rd_eof = 1;
    tick(); idle_in();
    chk("R10 A done", tx_start, 1'b0);
    tick();
    chk("R10 frame B start", tx_start, 1'b1);
    rd_en = 1; rd_eof = 1;
    tick(); idle_in(); fifo_level = '0;
    chk("R10 B done", tx_start, 1'b0);
    tick();
    chk("R10 no phantom frame", tx_start, 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule